// File: doc/BRIEF.md
# Clock Fanout Enable Controller with SMBus Block-Write Slave

This block gates one clock source onto eighteen outputs, each with its own enable. The enables are loaded over a two-wire bus. The block acts as a write-only slave: it decodes SMBus block writes made of an address byte, a command byte, a count byte and a run of data bytes. The first data byte of every transfer lands in enable register 0, the next in register 1 and the third in register 2. Any further bytes are acknowledged and dropped. A disabled output is held low. A separate active-high enable input drives the tri-state enable vector for the whole bank.

The two bus lines are sampled by a faster system clock. Each line passes through a synchronizer chain, and the sampled lines drive edge and condition detectors. A state machine with the states ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_CMD, ST_CMD_ACK, ST_COUNT, ST_COUNT_ACK, ST_DATA and ST_DATA_ACK follows the frame. Every state moves to ST_ADDR on a start condition and to ST_IDLE on a stop condition. A receive state passes to its acknowledge state on the SCL fall that follows its eighth bit. ST_ADDR goes back to ST_IDLE instead if the address does not match. Each acknowledge state moves on at the SCL fall that ends the ninth clock, in this order: ST_ADDR_ACK to ST_CMD, ST_CMD_ACK to ST_COUNT, ST_COUNT_ACK to ST_DATA, and ST_DATA_ACK back to ST_DATA.

Top module: `clkfan_ctrl`

## Requirements
- R1: An address byte of 0xD2 (7-bit address 1101001, then a write bit of 0) is acknowledged. The slave acknowledges by asserting sda_drive_low_o while SCL is high during the ninth clock.
- R2: An address byte with any other value is not acknowledged, and the bytes that follow it have no effect until the next start. This includes the read form 0xD3 and the general-call value 0x00.
- R3: After a matching address, the slave acknowledges the command byte, the count byte and every data byte.
- R4: Each byte is shifted in with its most significant bit first. Data bytes go in order to register 0, then 1, then 2. Data bytes after the third are acknowledged but not stored.
- R5: The enable vector is mapped as follows. Bits 7..0 of register 0 drive enables 7..0, and bits 7..0 of register 1 drive enables 15..8. Bit 7 of register 2 drives enable 17 and bit 6 drives enable 16. Bits 5..0 of register 2 have no effect.
- R6: clk_out_o[i] follows clk_src_i while enable i is 1, and it is 0 while enable i is 0.
- R7: After reset all eighteen enables are 1.
- R8: clk_out_en_o is all ones while oe_i is 1 and all zeros while oe_i is 0, whatever the register contents.
- R9: A start condition (SDA falling while SCL is high) restarts address matching from any state. A stop condition (SDA rising while SCL is high) returns the slave to idle. A byte cut short by either condition is not committed, and the registers keep their values.
- R10: The values of the command byte and the count byte are not used. Any value is accepted, including a count of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_drive_low_o | output | 1 | 1 pulls the data line low (acknowledge) |
| clk_src_i | input | 1 | Clock source to be fanned out |
| oe_i | input | 1 | Global output enable, active high |
| clk_out_o | output | 18 | Gated clock outputs |
| clk_out_en_o | output | 18 | Tri-state enable for each clock output |

## Verification
The embedded assertions check the following on every cycle. A start always leads to address reception, and a stop always leads to idle. An acknowledge is raised only after exactly eight bits have been shifted in. An acknowledge after the address only follows a matching address byte. The bit counter never passes eight. A write lasts one cycle. The enable bank changes only when a write is issued. The bench scenarios check the behaviour seen at the ports: the byte-to-output mapping over a sweep of patterns and transfer lengths, dropped extra bytes, rejected addresses, aborted bytes and repeated starts.

// File: rtl/clkfan_pkg.sv
package clkfan_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_COUNT,
        ST_COUNT_ACK,
        ST_DATA,
        ST_DATA_ACK
    } fsm_state_t;

    localparam logic [6:0] DEF_SLAVE_ADDR = 7'h69;

endpackage

// File: rtl/clkfan_bus_sampler.sv
module clkfan_bus_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic sda_bit
);
    logic [SYNC_STAGES-1:0] scl_sync;
    logic [SYNC_STAGES-1:0] sda_sync;
    logic                   scl_d;
    logic                   sda_d;
    logic                   scl_q;
    logic                   sda_q;

    assign scl_q = scl_sync[SYNC_STAGES-1];
    assign sda_q = sda_sync[SYNC_STAGES-1];

    // Synchronizer chains followed by one history stage (idle bus is high).
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sync <= '1;
            sda_sync <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
            sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
            scl_d    <= scl_q;
            sda_d    <= sda_q;
        end
    end

    always_comb begin
        scl_rise  = scl_q & ~scl_d;
        scl_fall  = ~scl_q & scl_d;
        start_det = scl_q & scl_d & sda_d & ~sda_q;
        stop_det  = scl_q & scl_d & ~sda_d & sda_q;
        sda_bit   = sda_q;
    end

endmodule

// File: rtl/clkfan_wr_fsm.sv
module clkfan_wr_fsm
    import clkfan_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR = DEF_SLAVE_ADDR,
    parameter int         NUM_REGS   = 3,
    parameter int         REG_W      = 8,
    parameter int         IDX_W      = $clog2(NUM_REGS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic             sda_bit,
    output logic             sda_drive,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [REG_W-1:0] wr_data
);
    localparam logic [3:0]       BITS_FULL = 4'(REG_W);
    localparam logic [REG_W-1:0] ADDR_BYTE = REG_W'({SLAVE_ADDR, 1'b0});
    localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(NUM_REGS);

    fsm_state_t       state;
    fsm_state_t       state_n;
    logic [3:0]       bit_cnt;
    logic [REG_W-1:0] shreg;
    logic [IDX_W-1:0] data_idx;
    logic             receiving;
    logic             acking;
    logic             byte_done;
    logic             addr_hit;

    always_comb begin
        receiving = (state == ST_ADDR) || (state == ST_CMD) ||
                    (state == ST_COUNT) || (state == ST_DATA);
        acking    = (state == ST_ADDR_ACK) || (state == ST_CMD_ACK) ||
                    (state == ST_COUNT_ACK) || (state == ST_DATA_ACK);
        byte_done = receiving && scl_fall && (bit_cnt == BITS_FULL);
        addr_hit  = (shreg == ADDR_BYTE);
    end

    // Next-state logic
    always_comb begin
        state_n = state;
        if (start_det) begin
            state_n = ST_ADDR;
        end else if (stop_det) begin
            state_n = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:      state_n = ST_IDLE;
                ST_ADDR:      if (byte_done) state_n = addr_hit ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK:  if (scl_fall) state_n = ST_CMD;
                ST_CMD:       if (byte_done) state_n = ST_CMD_ACK;
                ST_CMD_ACK:   if (scl_fall) state_n = ST_COUNT;
                ST_COUNT:     if (byte_done) state_n = ST_COUNT_ACK;
                ST_COUNT_ACK: if (scl_fall) state_n = ST_DATA;
                ST_DATA:      if (byte_done) state_n = ST_DATA_ACK;
                ST_DATA_ACK:  if (scl_fall) state_n = ST_DATA;
                default:      state_n = ST_IDLE;
            endcase
        end
    end

    // State register and receive datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            shreg    <= '0;
            data_idx <= '0;
        end else begin
            state <= state_n;
            if (start_det || stop_det) begin
                bit_cnt <= '0;
            end else if (receiving && scl_rise && (bit_cnt < BITS_FULL)) begin
                shreg   <= {shreg[REG_W-2:0], sda_bit};
                bit_cnt <= bit_cnt + 4'd1;
            end else if (acking && scl_fall) begin
                bit_cnt <= '0;
            end
            if (start_det) begin
                data_idx <= '0;
            end else if ((state == ST_DATA) && byte_done && (data_idx < IDX_LAST)) begin
                data_idx <= data_idx + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        sda_drive = acking;
        wr_en     = (state == ST_DATA) && byte_done && (data_idx < IDX_LAST);
        wr_idx    = data_idx;
        wr_data   = shreg;
    end

    AST_START_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_ADDR)); // R9
    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE)); // R9
    AST_ADDR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_ADDR_ACK) && ($past(state) == ST_ADDR)) |-> ($past(shreg) == ADDR_BYTE)); // R1
    AST_ACK_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_drive) |-> ($past(bit_cnt) == BITS_FULL)); // R3
    AST_BITCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= BITS_FULL); // R3
    AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en); // R4

endmodule

// File: rtl/clkfan_en_regs.sv
module clkfan_en_regs #(
    parameter int NUM_OUTS = 18,
    parameter int NUM_REGS = 3,
    parameter int REG_W    = 8,
    parameter int IDX_W    = $clog2(NUM_REGS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [REG_W-1:0]    wr_data,
    output logic [NUM_OUTS-1:0] en_o
);
    localparam int TAIL = NUM_OUTS - (NUM_REGS - 1) * REG_W;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        if (g < NUM_REGS - 1) begin : g_full
            logic [REG_W-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q <= '1;
                end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                    q <= wr_data;
                end
            end
            assign en_o[g*REG_W +: REG_W] = q;
        end else begin : g_tail
            // Only the upper bits of the last register reach outputs.
            logic [TAIL-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q <= '1;
                end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                    q <= wr_data[REG_W-1 -: TAIL];
                end
            end
            assign en_o[NUM_OUTS-1 -: TAIL] = q;
        end
    end

    AST_HOLD_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(en_o)); // R9

endmodule

// File: rtl/clkfan_gate.sv
module clkfan_gate #(
    parameter int NUM_OUTS = 18
) (
    input  logic                clk_src_i,
    input  logic                oe_i,
    input  logic [NUM_OUTS-1:0] en_i,
    output logic [NUM_OUTS-1:0] clk_out_o,
    output logic [NUM_OUTS-1:0] clk_out_en_o
);
    for (genvar i = 0; i < NUM_OUTS; i++) begin : g_out
        assign clk_out_o[i]    = clk_src_i & en_i[i];
        assign clk_out_en_o[i] = oe_i;
    end

endmodule

// File: rtl/clkfan_ctrl.sv
module clkfan_ctrl
    import clkfan_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR  = DEF_SLAVE_ADDR,
    parameter int         NUM_OUTS    = 18,
    parameter int         REG_W       = 8,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_i,
    input  logic                sda_i,
    output logic                sda_drive_low_o,
    input  logic                clk_src_i,
    input  logic                oe_i,
    output logic [NUM_OUTS-1:0] clk_out_o,
    output logic [NUM_OUTS-1:0] clk_out_en_o
);
    localparam int NUM_REGS = (NUM_OUTS + REG_W - 1) / REG_W;
    localparam int IDX_W    = $clog2(NUM_REGS + 1);

    logic             scl_rise;
    logic             scl_fall;
    logic             start_det;
    logic             stop_det;
    logic             sda_bit;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [REG_W-1:0] wr_data;
    logic [NUM_OUTS-1:0] en;

    clkfan_bus_sampler #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_bit   (sda_bit)
    );

    clkfan_wr_fsm #(
        .SLAVE_ADDR (SLAVE_ADDR),
        .NUM_REGS   (NUM_REGS),
        .REG_W      (REG_W),
        .IDX_W      (IDX_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_bit   (sda_bit),
        .sda_drive (sda_drive_low_o),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data)
    );

    clkfan_en_regs #(
        .NUM_OUTS (NUM_OUTS),
        .NUM_REGS (NUM_REGS),
        .REG_W    (REG_W),
        .IDX_W    (IDX_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .en_o    (en)
    );

    clkfan_gate #(
        .NUM_OUTS (NUM_OUTS)
    ) u_gate (
        .clk_src_i    (clk_src_i),
        .oe_i         (oe_i),
        .en_i         (en),
        .clk_out_o    (clk_out_o),
        .clk_out_en_o (clk_out_en_o)
    );

endmodule

// File: tb/tb_clkfan_ctrl.sv
`timescale 1ns/1ps
module tb_clkfan_ctrl;
    localparam int H = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_bus;
    logic        sda_drv;
    logic        clk_src = 1'b0;
    logic        oe = 1'b1;
    logic [17:0] clk_out;
    logic [17:0] clk_out_en;

    int          total = 0;
    int          bad = 0;
    logic [17:0] exp_en;
    logic [7:0]  pay [0:5];

    always #2.5 clk = ~clk;

    assign sda_bus = sda_m & ~sda_drv;

    clkfan_ctrl dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .scl_i           (scl),
        .sda_i           (sda_bus),
        .sda_drive_low_o (sda_drv),
        .clk_src_i       (clk_src),
        .oe_i            (oe),
        .clk_out_o       (clk_out),
        .clk_out_en_o    (clk_out_en)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [17:0] act, input logic [17:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_clk(H);
        scl = 1'b1;   wait_clk(H);
        sda_m = 1'b0; wait_clk(H);
        scl = 1'b0;   wait_clk(4);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_clk(H);
        scl = 1'b1;   wait_clk(H);
        sda_m = 1'b1; wait_clk(H);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int k = 7; k > 7 - n; k--) begin
            wait_clk(6);
            sda_m = b[k];
            wait_clk(H - 6);
            scl = 1'b1;
            wait_clk(H);
            scl = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        wait_clk(6);
        sda_m = 1'b1;
        wait_clk(H - 6);
        scl = 1'b1;
        wait_clk(H / 2);
        ack = ~sda_bus;
        wait_clk(H / 2);
        scl = 1'b0;
    endtask

    task automatic write_block(input logic [7:0] a, input logic [7:0] cmd, input logic [7:0] cnt,
                               input int n, output logic addr_ack, output logic all_ack,
                               output logic any_ack);
        logic ak;
        bus_start();
        send_byte(a, ak);
        addr_ack = ak; all_ack = ak; any_ack = ak;
        send_byte(cmd, ak); all_ack &= ak; any_ack |= ak;
        send_byte(cnt, ak); all_ack &= ak; any_ack |= ak;
        for (int k = 0; k < n; k++) begin
            send_byte(pay[k], ak); all_ack &= ak; any_ack |= ak;
        end
        bus_stop();
        wait_clk(8);
    endtask

    function automatic logic [17:0] apply(input logic [17:0] cur, input int n);
        logic [17:0] r = cur;
        if (n > 0) r[7:0]   = pay[0];
        if (n > 1) r[15:8]  = pay[1];
        if (n > 2) r[17:16] = pay[2][7:6];
        return r;
    endfunction

    task automatic check_outputs(input string tag);
        clk_src = 1'b1; wait_clk(1);
        check({tag, " R5 R6 high"}, clk_out, exp_en);
        clk_src = 1'b0; wait_clk(1);
        check({tag, " R6 low"}, clk_out, 18'h0);
    endtask

    initial begin
        logic aa, al, an;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        exp_en = 18'h3FFFF;

        // R7 reset state, R6 gating
        check_outputs("R7 reset");
        // R8 global enable
        oe = 1'b1; wait_clk(1);
        check("R8 oe high", clk_out_en, 18'h3FFFF);
        oe = 1'b0; wait_clk(1);
        check("R8 oe low", clk_out_en, 18'h0);
        clk_src = 1'b1; wait_clk(1);
        check("R8 R6 gating independent of oe", clk_out, 18'h3FFFF);
        clk_src = 1'b0;
        oe = 1'b1;

        // R1 R3 R4 R5 R10 sweep of patterns, lengths and count values
        for (int p = 0; p < 16; p++) begin
            int n;
            n = (p % 3) + 1;
            pay[0] = 8'(p * 37 + 5);
            pay[1] = 8'(p * 91) ^ 8'hA5;
            pay[2] = 8'(p * 53 + 64);
            write_block(8'hD2, 8'(p * 3), 8'(p), n, aa, al, an);
            check("R1 address ack", {17'h0, aa}, 18'h1);
            check("R3 R10 all bytes acked", {17'h0, al}, 18'h1);
            exp_en = apply(exp_en, n);
            check_outputs("R4 sweep");
        end

        // R4 extra bytes acked, not stored
        pay[0] = 8'h3C; pay[1] = 8'hC3; pay[2] = 8'h81;
        pay[3] = 8'h00; pay[4] = 8'h00; pay[5] = 8'h00;
        write_block(8'hD2, 8'h00, 8'h06, 6, aa, al, an);
        check("R4 extra bytes acked", {17'h0, al}, 18'h1);
        exp_en = apply(exp_en, 3);
        check_outputs("R4 extra bytes dropped");

        // R2 rejected addresses
        pay[0] = 8'h00; pay[1] = 8'h00; pay[2] = 8'h00;
        write_block(8'hD4, 8'h00, 8'h03, 3, aa, al, an);
        check("R2 wrong address no ack", {17'h0, an}, 18'h0);
        check_outputs("R2 wrong address ignored");
        write_block(8'hD3, 8'h00, 8'h03, 3, aa, al, an);
        check("R2 read request no ack", {17'h0, an}, 18'h0);
        check_outputs("R2 read ignored");
        write_block(8'h00, 8'h00, 8'h03, 3, aa, al, an);
        check("R2 general call no ack", {17'h0, an}, 18'h0);
        check_outputs("R2 general call ignored");

        // R9 stop in the middle of a data byte
        bus_start();
        send_byte(8'hD2, aa);
        send_byte(8'h00, aa);
        send_byte(8'h02, aa);
        send_byte(8'h5A, aa);
        send_bits(8'h00, 4);
        bus_stop();
        wait_clk(8);
        exp_en[7:0] = 8'h5A;
        check_outputs("R9 partial byte before stop");

        // R9 repeated start inside a data byte restarts matching
        bus_start();
        send_byte(8'hD2, aa);
        send_byte(8'h00, aa);
        send_byte(8'h01, aa);
        send_bits(8'h00, 3);
        pay[0] = 8'hF0; pay[1] = 8'h0F; pay[2] = 8'h40;
        write_block(8'hD2, 8'h11, 8'h00, 3, aa, al, an);
        check("R9 repeated start acked", {17'h0, al}, 18'h1);
        exp_en = apply(exp_en, 3);
        check_outputs("R9 repeated start");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule